// File: doc/BRIEF.md
# Block-Cipher Coprocessor FIFO Shell

This block is the data path that sits around a block-cipher core. A host processor or a DMA engine writes 32-bit words into an 8-word input queue. The shell gathers those words into cipher blocks and hands each complete block to a processing stage. The finished block is placed in an 8-word output queue, and the host or DMA engine reads it from there. A block is 2 words in the narrow mode and 4 words in the wide mode. The cipher rounds themselves are not part of this block. A placeholder transform with a fixed latency stands in for them, so every output word can be predicted from its input word.

Software reads four status flags: input empty, input not full, output not empty, and busy. It also sets masks for an input interrupt request and an output interrupt request, and it enables the input and output DMA requests separately. Blocks are only started while the global enable is set. A block that has already started always runs to the end. This lets software stop the input DMA requests, let the remaining results drain, and then clear the enable without losing any data. A flush control empties both queues, and it takes effect only while the global enable is clear.

Top module: `cipher_fifo_shell`

## Requirements
- R1: After reset, st_in_empty=1, st_in_not_full=1, st_out_not_empty=0, st_busy=0, and the interrupt and DMA request outputs are 0 while their enables and masks are 0.
- R2: With cfg_wide=0 a block is 2 words; with cfg_wide=1 it is 4 words. Output word k of a block (k counted from 0) equals input word k XOR (32'hA5C35A3C + k). Blocks and words come out in the order they were written.
- R3: The input queue holds 8 words. A write while it holds 8 words is dropped, and st_in_not_full=0 while it is full.
- R4: While the output queue is empty, out_data reads 0, and a read strobe leaves the queue unchanged.
- R5: A block starts only when the input queue holds a whole block and the output queue has room for a whole block. Otherwise st_busy stays 0 and the input words stay queued.
- R6: Once a block starts, st_busy is 1 for exactly 4 cycles. Its result words are in the output queue in the cycle after st_busy falls.
- R7: The status flags track the queues. st_in_empty means the input queue holds 0 words, and st_out_not_empty means the output queue holds at least 1 word. When all data has been processed and read, st_busy=0, st_in_empty=1 and st_out_not_empty=0.
- R8: irq_in is 1 exactly when irq_in_mask=1 and the input queue is not full. irq_out is 1 exactly when irq_out_mask=1 and the output queue is not empty.
- R9: dma_in_req is 1 exactly when dma_in_en=1 and the input queue is not full. dma_out_req is 1 exactly when dma_out_en=1 and the output queue is not empty. Clearing dma_in_en stops input requests at once and does not affect output requests.
- R10: No block starts while cfg_enable=0. Words written while the block is disabled are kept and processed after cfg_enable is set.
- R11: cfg_flush=1 with cfg_enable=0 empties both queues and abandons any block in progress within one cycle. cfg_flush=1 with cfg_enable=1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Global enable; blocks start only while it is 1 |
| cfg_wide | input | 1 | Block size: 0 for 2 words, 1 for 4 words |
| cfg_flush | input | 1 | Empties both queues when cfg_enable is 0 |
| irq_in_mask | input | 1 | Unmasks the input interrupt request |
| irq_out_mask | input | 1 | Unmasks the output interrupt request |
| dma_in_en | input | 1 | Enables input DMA requests |
| dma_out_en | input | 1 | Enables output DMA requests |
| in_valid | input | 1 | Write strobe for the input queue |
| in_data | input | 32 | Word to write |
| out_rd | input | 1 | Read strobe; removes the head word of the output queue |
| out_data | output | 32 | Head word of the output queue, or 0 when it is empty |
| st_in_empty | output | 1 | Input queue holds no words |
| st_in_not_full | output | 1 | Input queue can take a word |
| st_out_not_empty | output | 1 | Output queue holds a word |
| st_busy | output | 1 | A block is being processed |
| irq_in | output | 1 | Input interrupt request |
| irq_out | output | 1 | Output interrupt request |
| dma_in_req | output | 1 | Input DMA request |
| dma_out_req | output | 1 | Output DMA request |

## Verification
The assertions check the following on every cycle:
- neither queue ever holds more than 8 words;
- a write to a full queue leaves its fill level at 8;
- an empty output queue reads as zero;
- the interrupt requests never point at a queue in the wrong state, and the input DMA request is silent while disabled;
- every busy period lasts exactly 4 cycles and is followed by a non-empty output queue;
- nothing starts while disabled;
- an accepted flush leaves both queues empty.

Only the bench scenarios can show that the words come out in the right order with the right values in both block sizes. The same applies to the other cases that need a sequence of operations: the dropped ninth word, the stall until output room frees up, the flush that is ignored while enabled, and the words written while disabled that survive until the enable is set.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

  // Placeholder cipher transform: each word is mixed with a lane-dependent constant.
  function automatic logic [31:0] cfs_mix(input logic [31:0] w, input logic [31:0] salt,
                                          input int unsigned lane);
    return w ^ (salt + 32'(lane));
  endfunction

  // Number of words per cipher block for the selected mode.
  function automatic int unsigned cfs_blk_words(input logic wide);
    return wide ? 4 : 2;
  endfunction

endpackage

// File: rtl/cfs_fifo.sv
module cfs_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned MAXN  = 4,
  parameter int unsigned NPEEK = 4,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1,
  localparam int unsigned NW   = $clog2(MAXN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [NW-1:0] push_n,
  input  logic [W-1:0]  push_data [MAXN],
  input  logic [NW-1:0] pop_n,
  output logic [W-1:0]  peek [NPEEK],
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp;
  logic [AW-1:0] rp;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      wp    <= wp + AW'(push_n);
      rp    <= rp + AW'(pop_n);
      count <= count + CW'(push_n) - CW'(pop_n);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < MAXN; i++) begin
      if (NW'(i) < push_n) mem[wp + AW'(i)] <= push_data[i];
    end
  end

  for (genvar g = 0; g < NPEEK; g++) begin : g_peek
    assign peek[g] = mem[rp + AW'(g)];
  end

endmodule

// File: rtl/cfs_engine.sv
module cfs_engine
  import cfs_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned MAXN  = 4,
  parameter int unsigned LAT   = 4,
  parameter logic [31:0] SALT  = 32'hA5C35A3C,
  localparam int unsigned CW   = $clog2(DEPTH) + 1,
  localparam int unsigned NW   = $clog2(MAXN + 1),
  localparam int unsigned LW   = $clog2(LAT) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          enable,
  input  logic          wide,
  input  logic [CW-1:0] in_count,
  input  logic [CW-1:0] out_count,
  input  logic [W-1:0]  in_peek [MAXN],
  output logic [NW-1:0] pop_n,
  output logic [NW-1:0] push_n,
  output logic [W-1:0]  push_data [MAXN],
  output logic          busy,
  output logic          start_evt,
  output logic          done_evt
);

  logic [W-1:0]  hold [MAXN];
  logic [NW-1:0] blk_n;
  logic [LW-1:0] cnt;
  logic [NW-1:0] bw;
  logic [CW-1:0] room;

  assign bw   = NW'(cfs_blk_words(wide));
  assign room = CW'(DEPTH) - out_count;

  assign start_evt = enable && !busy && !abort &&
                     (in_count >= CW'(bw)) && (room >= CW'(bw));
  assign done_evt  = busy && !abort && (cnt == LW'(LAT - 1));

  assign pop_n  = start_evt ? bw : '0;
  assign push_n = done_evt ? blk_n : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      busy  <= 1'b0;
      cnt   <= '0;
      blk_n <= '0;
    end else if (start_evt) begin
      busy  <= 1'b1;
      cnt   <= '0;
      blk_n <= bw;
    end else if (done_evt) begin
      busy  <= 1'b0;
      cnt   <= '0;
    end else if (busy) begin
      cnt   <= cnt + LW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (start_evt) begin
      for (int i = 0; i < MAXN; i++) hold[i] <= cfs_mix(in_peek[i], SALT, i);
    end
  end

  for (genvar g = 0; g < MAXN; g++) begin : g_out
    assign push_data[g] = hold[g];
  end

endmodule

// File: rtl/cipher_fifo_shell.sv
module cipher_fifo_shell #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned LAT    = 4,
  parameter logic [31:0] SALT   = 32'hA5C35A3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_wide,
  input  logic              cfg_flush,
  input  logic              irq_in_mask,
  input  logic              irq_out_mask,
  input  logic              dma_in_en,
  input  logic              dma_out_en,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  logic              out_rd,
  output logic [WORD_W-1:0] out_data,
  output logic              st_in_empty,
  output logic              st_in_not_full,
  output logic              st_out_not_empty,
  output logic              st_busy,
  output logic              irq_in,
  output logic              irq_out,
  output logic              dma_in_req,
  output logic              dma_out_req
);

  localparam int unsigned MAXN = 4;
  localparam int unsigned CW   = $clog2(DEPTH) + 1;
  localparam int unsigned NW   = $clog2(MAXN + 1);

  logic [CW-1:0]     in_cnt;
  logic [CW-1:0]     out_cnt;
  logic [NW-1:0]     in_push_n;
  logic [NW-1:0]     in_pop_n;
  logic [NW-1:0]     out_push_n;
  logic [NW-1:0]     out_pop_n;
  logic [WORD_W-1:0] in_lanes  [MAXN];
  logic [WORD_W-1:0] in_peek   [MAXN];
  logic [WORD_W-1:0] res_lanes [MAXN];
  logic [WORD_W-1:0] out_peek  [1];
  logic              flush_ok;
  logic              eng_start;
  logic              eng_done;

  // Named internal events for the checker.
  assign flush_ok  = cfg_flush && !cfg_enable;
  assign in_push_n = (in_valid && (in_cnt < CW'(DEPTH))) ? NW'(1) : '0;
  assign out_pop_n = (out_rd && (out_cnt != '0)) ? NW'(1) : '0;

  assign in_lanes[0] = in_data;
  for (genvar g = 1; g < MAXN; g++) begin : g_zero
    assign in_lanes[g] = '0;
  end

  cfs_fifo #(.W(WORD_W), .DEPTH(DEPTH), .MAXN(MAXN), .NPEEK(MAXN)) in_q (
    .clk(clk), .rst_n(rst_n), .clear(flush_ok),
    .push_n(in_push_n), .push_data(in_lanes),
    .pop_n(in_pop_n), .peek(in_peek), .count(in_cnt)
  );

  cfs_engine #(.W(WORD_W), .DEPTH(DEPTH), .MAXN(MAXN), .LAT(LAT), .SALT(SALT)) eng (
    .clk(clk), .rst_n(rst_n), .abort(flush_ok), .enable(cfg_enable), .wide(cfg_wide),
    .in_count(in_cnt), .out_count(out_cnt), .in_peek(in_peek),
    .pop_n(in_pop_n), .push_n(out_push_n), .push_data(res_lanes),
    .busy(st_busy), .start_evt(eng_start), .done_evt(eng_done)
  );

  cfs_fifo #(.W(WORD_W), .DEPTH(DEPTH), .MAXN(MAXN), .NPEEK(1)) out_q (
    .clk(clk), .rst_n(rst_n), .clear(flush_ok),
    .push_n(out_push_n), .push_data(res_lanes),
    .pop_n(out_pop_n), .peek(out_peek), .count(out_cnt)
  );

  assign st_in_empty      = (in_cnt == '0);
  assign st_in_not_full   = (in_cnt < CW'(DEPTH));
  assign st_out_not_empty = (out_cnt != '0);
  assign out_data         = st_out_not_empty ? out_peek[0] : '0;

  assign irq_in      = irq_in_mask  && st_in_not_full;
  assign irq_out     = irq_out_mask && st_out_not_empty;
  assign dma_in_req  = dma_in_en    && st_in_not_full;
  assign dma_out_req = dma_out_en   && st_out_not_empty;

endmodule

// File: rtl/cipher_fifo_shell_chk.sv
module cipher_fifo_shell_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LAT   = 4,
  localparam int unsigned CW   = $clog2(DEPTH) + 1,
  localparam int unsigned RW   = $clog2(LAT + 2) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_enable,
  input logic          in_valid,
  input logic          dma_in_en,
  input logic          dma_in_req,
  input logic          irq_in,
  input logic          irq_out,
  input logic          st_busy,
  input logic          st_in_empty,
  input logic          st_out_not_empty,
  input logic [31:0]   out_data,
  input logic [CW-1:0] in_cnt,
  input logic [CW-1:0] out_cnt,
  input logic          flush_ok,
  input logic          eng_start,
  input logic          eng_done
);

  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else if (st_busy) run <= run + RW'(1);
    else run <= '0;
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cnt <= CW'(DEPTH)) && (out_cnt <= CW'(DEPTH)));

  a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cnt == CW'(DEPTH) && in_valid && !eng_start && !flush_ok) |=> (in_cnt == CW'(DEPTH)));

  a_r4_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cnt == '0) |-> (out_data == 32'd0));

  a_r6_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(st_busy) && !$past(flush_ok)) |-> (run == RW'(LAT)));

  a_r6_done_fills: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> st_out_not_empty);

  a_r8_irq_in_room: assert property (@(posedge clk) disable iff (!rst_n)
    irq_in |-> (in_cnt < CW'(DEPTH)));

  a_r8_irq_out_data: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (out_cnt != '0));

  a_r9_dma_in_off: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_in_en |-> !dma_in_req);

  a_r10_no_start_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_enable && !st_busy) |=> !st_busy);

  a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_ok |=> (st_in_empty && !st_out_not_empty && !st_busy));

endmodule

bind cipher_fifo_shell cipher_fifo_shell_chk #(.DEPTH(DEPTH), .LAT(LAT)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .in_valid(in_valid),
  .dma_in_en(dma_in_en), .dma_in_req(dma_in_req), .irq_in(irq_in), .irq_out(irq_out),
  .st_busy(st_busy), .st_in_empty(st_in_empty), .st_out_not_empty(st_out_not_empty),
  .out_data(out_data), .in_cnt(in_cnt), .out_cnt(out_cnt), .flush_ok(flush_ok),
  .eng_start(eng_start), .eng_done(eng_done)
);

// File: tb/cipher_fifo_shell_tb_top.sv
`timescale 1ns/1ps
module cipher_fifo_shell_tb_top;

  localparam logic [31:0] TB_SALT = 32'hA5C35A3C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_enable = 0, cfg_wide = 0, cfg_flush = 0;
  logic irq_in_mask = 0, irq_out_mask = 0, dma_in_en = 0, dma_out_en = 0;
  logic in_valid = 0, out_rd = 0;
  logic [31:0] in_data = '0;
  logic [31:0] out_data;
  logic st_in_empty, st_in_not_full, st_out_not_empty, st_busy;
  logic irq_in, irq_out, dma_in_req, dma_out_req;

  int unsigned total = 0;
  int unsigned bad = 0;
  logic [31:0] expq [$];
  int unsigned lane = 0;
  int unsigned bw = 2;

  always #4 clk = ~clk;

  cipher_fifo_shell dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_wide(cfg_wide),
    .cfg_flush(cfg_flush), .irq_in_mask(irq_in_mask), .irq_out_mask(irq_out_mask),
    .dma_in_en(dma_in_en), .dma_out_en(dma_out_en), .in_valid(in_valid),
    .in_data(in_data), .out_rd(out_rd), .out_data(out_data),
    .st_in_empty(st_in_empty), .st_in_not_full(st_in_not_full),
    .st_out_not_empty(st_out_not_empty), .st_busy(st_busy),
    .irq_in(irq_in), .irq_out(irq_out), .dma_in_req(dma_in_req), .dma_out_req(dma_out_req)
  );

  // Expected result word for lane k of a block.
  function automatic logic [31:0] expect_word(input logic [31:0] w, input int unsigned k);
    logic [31:0] key;
    key = TB_SALT + k;
    return ~(~w ^ key);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic wide);
    cfg_wide = wide;
    bw = wide ? 4 : 2;
    lane = 0;
  endtask

  // One write; optionally recorded in the model.
  task automatic wr(input logic [31:0] w, input bit model);
    in_valid = 1'b1;
    in_data = w;
    @(negedge clk);
    in_valid = 1'b0;
    if (model) begin
      expq.push_back(expect_word(w, lane));
      lane = (lane + 1) % bw;
    end
  endtask

  task automatic rd_chk(input string tag);
    logic [31:0] e;
    e = expq.pop_front();
    chk(tag, out_data, e);
    out_rd = 1'b1;
    @(negedge clk);
    out_rd = 1'b0;
  endtask

  task automatic drain(input string tag);
    int guard = 0;
    while (expq.size() > 0 && guard < 3000) begin
      if (st_out_not_empty) rd_chk(tag);
      else tick(1);
      guard++;
    end
    chk({tag, " all results read"}, 32'(expq.size()), 32'd0);
    tick(2);
    chk("R7 idle in_empty", 32'(st_in_empty), 32'd1);
    chk("R7 idle out_not_empty", 32'(st_out_not_empty), 32'd0);
    chk("R7 idle busy", 32'(st_busy), 32'd0);
  endtask

  initial begin
    #(8ns * 190000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h00C0FFEE);
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    chk("R1 in_empty", 32'(st_in_empty), 32'd1);
    chk("R1 in_not_full", 32'(st_in_not_full), 32'd1);
    chk("R1 out_not_empty", 32'(st_out_not_empty), 32'd0);
    chk("R1 busy", 32'(st_busy), 32'd0);
    chk("R1 requests", {28'd0, irq_in, irq_out, dma_in_req, dma_out_req}, 32'd0);

    // R10: words held while disabled; R6 latency; R2 narrow values
    set_mode(1'b0);
    wr(32'h1111_0000, 1);
    wr(32'h2222_0001, 1);
    tick(4);
    chk("R10 no start while disabled", 32'(st_busy), 32'd0);
    chk("R10 words kept", 32'(st_in_empty), 32'd0);
    cfg_enable = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick(1);
      chk("R6 busy during block", 32'(st_busy), 32'd1);
    end
    tick(1);
    chk("R6 busy released", 32'(st_busy), 32'd0);
    chk("R6 result present", 32'(st_out_not_empty), 32'd1);
    rd_chk("R2 narrow word0");
    rd_chk("R2 narrow word1");
    // R4 empty read
    chk("R4 empty reads zero", out_data, 32'd0);
    out_rd = 1'b1;
    tick(1);
    out_rd = 1'b0;
    chk("R4 empty read keeps empty", 32'(st_out_not_empty), 32'd0);
    chk("R4 still zero", out_data, 32'd0);

    // R3 overflow drop, wide mode
    cfg_enable = 1'b0;
    set_mode(1'b1);
    for (int i = 0; i < 8; i++) wr(32'hA000_0000 + 32'(i), 1);
    chk("R3 full flag", 32'(st_in_not_full), 32'd0);
    wr(32'hDEAD_BEEF, 0);
    chk("R3 still full after drop", 32'(st_in_not_full), 32'd0);
    cfg_enable = 1'b1;
    drain("R3 R2 wide order");

    // R5 output room stall
    for (int i = 0; i < 8; i++) wr(32'hB000_0000 + 32'(i * 7), 1);
    tick(20);
    for (int i = 0; i < 4; i++) wr(32'hC000_0000 + 32'(i), 1);
    tick(10);
    chk("R5 stall busy low", 32'(st_busy), 32'd0);
    chk("R5 input kept", 32'(st_in_empty), 32'd0);
    drain("R5 after stall");

    // R8 R9 interrupts and DMA
    cfg_enable = 1'b0;
    irq_in_mask = 1; irq_out_mask = 1; dma_in_en = 1; dma_out_en = 1;
    tick(1);
    chk("R8 irq_in empty queue", 32'(irq_in), 32'd1);
    chk("R8 irq_out no data", 32'(irq_out), 32'd0);
    chk("R9 dma_in_req room", 32'(dma_in_req), 32'd1);
    chk("R9 dma_out_req no data", 32'(dma_out_req), 32'd0);
    for (int i = 0; i < 8; i++) wr(32'h5500_0000 ^ 32'(i << 8), 1);
    chk("R8 irq_in full", 32'(irq_in), 32'd0);
    chk("R9 dma_in_req full", 32'(dma_in_req), 32'd0);
    cfg_enable = 1'b1;
    tick(6);
    chk("R8 irq_out data", 32'(irq_out), 32'd1);
    chk("R9 dma_out_req data", 32'(dma_out_req), 32'd1);
    dma_in_en = 1'b0;
    tick(1);
    chk("R9 dma_in stopped", 32'(dma_in_req), 32'd0);
    chk("R9 dma_out continues", 32'(dma_out_req), 32'd1);
    drain("R9 drain");
    irq_in_mask = 0; irq_out_mask = 0; dma_out_en = 0;
    tick(1);
    chk("R8 masked", {30'd0, irq_in, irq_out}, 32'd0);

    // R11 flush
    set_mode(1'b0);
    wr(32'h0F0F_0F0F, 0);
    wr(32'hF0F0_F0F0, 0);
    tick(8);
    chk("R11 setup out data", 32'(st_out_not_empty), 32'd1);
    set_mode(1'b1);
    for (int i = 0; i < 3; i++) wr(32'h7777_0000 + 32'(i), 0);
    tick(6);
    chk("R5 partial block no start", 32'(st_busy), 32'd0);
    cfg_flush = 1'b1;
    tick(1);
    cfg_flush = 1'b0;
    chk("R11 ignored when enabled in", 32'(st_in_empty), 32'd0);
    chk("R11 ignored when enabled out", 32'(st_out_not_empty), 32'd1);
    cfg_enable = 1'b0;
    cfg_flush = 1'b1;
    tick(1);
    cfg_flush = 1'b0;
    chk("R11 flush in", 32'(st_in_empty), 32'd1);
    chk("R11 flush out", 32'(st_out_not_empty), 32'd0);
    chk("R11 flush zero out", out_data, 32'd0);
    cfg_enable = 1'b1;

    // Random interleaved traffic
    for (int it = 0; it < 16; it++) begin
      int unsigned words;
      int unsigned done_w;
      set_mode(1'($urandom % 2));
      words = bw * (1 + $urandom % 5);
      done_w = 0;
      while (done_w < words) begin
        if (st_out_not_empty && ($urandom % 3 == 0)) rd_chk("R2 random stream");
        else if (st_in_not_full && ($urandom % 4 != 0)) begin
          wr($urandom, 1);
          done_w++;
        end else tick(1);
      end
      drain("R2 random drain");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule